// File: doc/BRIEF.md
# Signed Peak Amplitude Meter

This block watches a stream of signed two's-complement samples that arrive at the decimated (Nyquist) rate, one per clock cycle in which the sample strobe is high. It keeps a running maximum and a running minimum of the samples in the current measurement window. A window is a fixed number of accepted samples, 2^CNT_W, timed by a counter of CNT_W bits (24 by default). The sample and both trackers are DATA_W bits wide (16 by default).

When the last sample of a window is accepted, that sample is folded into the extremes. The final maximum and minimum are then copied into the output registers, and a one-cycle done pulse is raised. Both trackers restart from their extreme starting values, so the next window begins from its own first sample. Between done pulses the outputs hold the result of the last completed window. Downstream logic reads them when the pulse appears.

Top module: `peak_meter`

## Requirements
- R1: The asynchronous active-low reset clears max_o, min_o and done_o to zero and restarts the window count, so a window after reset ends on the 2^CNT_W-th strobed sample accepted after the release.
- R2: Samples are compared as two's-complement signed numbers: 16'h7FFF (+32767) ranks above 16'h0000, which ranks above 16'h8000 (-32768).
- R3: At the end of a window, max_o equals the largest sample accepted in that window.
- R4: At the end of a window, min_o equals the smallest sample accepted in that window.
- R5: A window ends on the 2^CNT_W-th accepted sample. done_o is high for exactly one clock cycle, starting at the clock edge that accepts that sample, and is low at all other times.
- R6: The sample accepted at the edge that ends a window is included in that window's max_o and min_o.
- R7: Each window starts with its maximum tracker at the most negative value and its minimum tracker at the most positive value. Extremes never carry over between windows: a window whose samples are all equal to v reports max_o = min_o = v, including v = -32768 and v = +32767.
- R8: A cycle with sample_valid_i low has no effect: the value on sample_i is neither compared nor counted toward the window.
- R9: max_o and min_o change only at the edge that raises done_o and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe; sample_i is accepted at the rising edge while high |
| sample_i | input | DATA_W | Signed two's-complement sample |
| max_o | output | DATA_W | Largest sample of the last completed window |
| min_o | output | DATA_W | Smallest sample of the last completed window |
| done_o | output | 1 | One-cycle pulse when max_o and min_o take a new window's result |

## Verification
Two functions fall on the same clock edge: folding a new extreme into the trackers, and closing the window, which latches the result and reloads the trackers.

The bench provokes this by sending strobes back to back and placing the window's peak or trough on the final sample. It also sends the first sample of the next window at the very next edge.

The check passes only if the output shows the final sample and the following window reports its own extremes with no trace of that sample. This is judged against a bench model that counts accepted samples, including across idle gaps carrying extreme values, and across a reset in mid-window.

// File: rtl/peak_pkg.sv
package peak_pkg;
  typedef enum logic {
    TRACK_MAX = 1'b0,
    TRACK_MIN = 1'b1
  } track_kind_e;

  localparam int unsigned N_TRACKERS = 2;
endpackage

// File: rtl/peak_tracker.sv
module peak_tracker #(
  parameter int unsigned             DATA_W = 16,
  parameter peak_pkg::track_kind_e   KIND   = peak_pkg::TRACK_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              restart_i,
  output logic [DATA_W-1:0] best_o
);
  localparam logic [DATA_W-1:0] S_POS  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_NEG  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] INIT_V = (KIND == peak_pkg::TRACK_MAX) ? S_NEG : S_POS;

  logic [DATA_W-1:0] held_q;
  logic              take;

  always_comb begin
    if (KIND == peak_pkg::TRACK_MAX) take = $signed(sample_i) > $signed(held_q);
    else                             take = $signed(sample_i) < $signed(held_q);
  end

  // merged extreme including the sample offered this cycle
  assign best_o = (valid_i && take) ? sample_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= INIT_V;
    else if (valid_i) held_q <= restart_i ? INIT_V : best_o;
  end

  if (KIND == peak_pkg::TRACK_MAX) begin : g_max_chk
    AST_MAX_COVERS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !restart_i |=> $signed(held_q) >= $signed($past(sample_i))); // R3
    AST_MAX_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !restart_i |=> $signed(held_q) >= $signed($past(held_q))); // R3
  end else begin : g_min_chk
    AST_MIN_COVERS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !restart_i |=> $signed(held_q) <= $signed($past(sample_i))); // R4
    AST_MIN_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !restart_i |=> $signed(held_q) <= $signed($past(held_q))); // R4
  end

  AST_TRACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(held_q)); // R8
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = valid_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q)); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R5
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] max_i,
  input  logic [DATA_W-1:0] min_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o  <= '0;
      min_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        max_o <= max_i;
        min_o <= min_i;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(max_o) && $stable(min_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_OUT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $signed(max_o) >= $signed(min_o)); // R2
endmodule

// File: rtl/peak_meter.sv
module peak_meter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o,
  output logic              done_o
);
  localparam int unsigned NT = peak_pkg::N_TRACKERS;

  logic              wrap;
  logic [DATA_W-1:0] best [NT];

  window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .wrap_o  (wrap)
  );

  for (genvar k = 0; k < NT; k++) begin : g_trk
    peak_tracker #(
      .DATA_W (DATA_W),
      .KIND   (peak_pkg::track_kind_e'(k))
    ) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (sample_valid_i),
      .sample_i  (sample_i),
      .restart_i (wrap),
      .best_o    (best[k])
    );
  end

  peak_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .max_i  (best[int'(peak_pkg::TRACK_MAX)]),
    .min_i  (best[int'(peak_pkg::TRACK_MIN)]),
    .max_o  (max_o),
    .min_o  (min_o),
    .done_o (done_o)
  );

  AST_DONE_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> done_o); // R5
  AST_LAST_SAMPLE_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> $signed(max_o) >= $signed($past(sample_i)) &&
             $signed(min_o) <= $signed($past(sample_i))); // R6
endmodule

// File: tb/tb_peak_meter.sv
module tb_peak_meter;
  localparam int DW  = 16;
  localparam int CW  = 3;
  localparam int WIN = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          vld = 1'b0;
  logic [DW-1:0] smp = '0;
  logic [DW-1:0] max_o, min_o;
  logic          done_o;

  int n_tests = 0, n_fail = 0;
  int m_cnt = 0, m_max = -32768, m_min = 32767;
  logic [DW-1:0] e_max = '0, e_min = '0;

  always #5 clk = ~clk;

  peak_meter #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(vld), .sample_i(smp),
    .max_o(max_o), .min_o(min_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: present inputs at a falling edge, check at the next falling edge
  task automatic step(input string tag, input logic v, input int val);
    logic e_done;
    vld = v;
    smp = DW'(val);
    e_done = 1'b0;
    if (v) begin
      m_cnt++;
      if (val > m_max) m_max = val;
      if (val < m_min) m_min = val;
      if (m_cnt == WIN) begin
        e_max = DW'(m_max); e_min = DW'(m_min); e_done = 1'b1;
        m_cnt = 0; m_max = -32768; m_min = 32767;
      end
    end
    @(negedge clk);
    chk(tag, "done_o", int'(done_o), int'(e_done));
    chk(tag, "max_o", int'(max_o), int'(e_max));
    chk(tag, "min_o", int'(min_o), int'(e_min));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; vld = 1'b0;
    @(negedge clk); @(negedge clk);
    m_cnt = 0; m_max = -32768; m_min = 32767; e_max = '0; e_min = '0;
    chk("R1", "max_o", int'(max_o), 0);
    chk("R1", "min_o", int'(min_o), 0);
    chk("R1", "done_o", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 3; i++) step("R1", 1'b1, 100 + i);
    do_reset();  // mid-window reset restarts the count
    for (int i = 0; i < WIN; i++) step("R1", 1'b1, i - 3);
  endtask

  task automatic t_signed();  // R2
    int vals[8] = '{0, 32767, -32768, 1, -1, 0, 500, -500};
    for (int i = 0; i < WIN; i++) step("R2", 1'b1, vals[i]);
  endtask

  task automatic t_ramp();  // R3 R4 R5 R9
    for (int i = 0; i < WIN; i++) step("R3", 1'b1, i * 1000 - 2000);
    for (int i = 0; i < WIN; i++) step("R4", 1'b1, 3000 - i * 700);
  endtask

  task automatic t_last_edge();  // R6: extreme on the closing sample, next window at once
    for (int i = 0; i < WIN - 1; i++) step("R6", 1'b1, i);
    step("R6", 1'b1, 30000);
    for (int i = 0; i < WIN - 1; i++) step("R6", 1'b1, 10 + i);
    step("R6", 1'b1, -30000);
    for (int i = 0; i < WIN; i++) step("R6", 1'b1, 5);
  endtask

  task automatic t_fresh();  // R7
    for (int i = 0; i < WIN; i++) step("R7", 1'b1, -32768);
    for (int i = 0; i < WIN; i++) step("R7", 1'b1, 32767);
    for (int i = 0; i < WIN; i++) step("R7", 1'b1, -7);
  endtask

  task automatic t_idle();  // R8 R9
    for (int i = 0; i < WIN; i++) begin
      step("R8", 1'b0, (i % 2) ? 32767 : -32768);
      step("R8", 1'b1, 40 - i);
      step("R9", 1'b0, 12345);
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_signed();
    t_ramp();
    t_last_edge();
    t_fresh();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule